// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus. It gives byte-addressed access to an 8K x 8 store that is held in an internal register array. SCL and SDA enter as raw levels and are oversampled by the system clock. The block drives SDA only through an open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line is released. A master selects the block with an address byte whose upper nibble is the device type. It then sends a 13-bit word address in two bytes, followed by data to be written.

Reads return bytes from an internal address pointer. That pointer survives from one transaction to the next, so a master can do three kinds of read. It can read from wherever the last access left off. It can aim the pointer with an address-only write and then issue a repeated start. It can stream through memory by acknowledging each byte. A completed write starts a self-timed programming interval whose length is a parameter. While that interval runs, `busy` is high and the block ignores its address, so a master can poll for completion.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` and `busy` are both low.
- R2: The block acknowledges an address byte (it pulls SDA low on the ninth clock) only when bits 7..4 equal 1010 and it is not busy. Bits 3..1 are don't-care. Bit 0 set to 1 selects a read. An address byte that does not match gets no acknowledge, and the block ignores every later byte until the next start.
- R3: In a write, the first byte after the address byte supplies word address bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte supplies bits 7..0. Each following data byte is acknowledged and stored at the current word address.
- R4: After each stored byte, only the low 6 bits of the word address advance. Writing past the end of a 64-byte page therefore wraps to the start of the same page and leaves the next page untouched.
- R5: A stop that ends a write containing at least one data byte holds `busy` high for WRITE_CYCLES clocks. While `busy` is high the address byte is not acknowledged. A stop after an address-only write leaves `busy` low.
- R6: A write of two word-address bytes, then a repeated start and an address byte with bit 0 set, returns the byte stored at that word address.
- R7: When the master acknowledges a read byte, the next byte comes from the following address. The pointer wraps from 8191 to 0.
- R8: A read that begins right after the address byte returns data from the address one past the last byte read or written, including across stop conditions. An address-only write sets this address.
- R9: After the master leaves SDA high on the ninth clock of a read byte, the block keeps SDA released on every following clock until the next start.
- R10: The block changes `sda_oe` only in the clock after it detects a falling SCL edge, a start or a stop. It sends data most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Raw serial clock level from the pad |
| sda_i | input | 1 | Raw serial data level from the pad (the wired line) |
| sda_oe | output | 1 | High pulls SDA low; low releases the line |
| busy | output | 1 | High during the self-timed write interval |

## Verification
The bench runs every kind of access through a behavioural model that keeps an image of memory and the expected pointer. It uses:
- random reads at a mid-page address, which separate pointer loading from data return;
- streamed reads across the 8191-to-0 boundary, which show full-width counting as distinct from page-limited counting;
- a four-byte write that starts two bytes before a page end, with the first byte of the next page read back, which proves the wrap stays inside the page;
- acknowledge polling during the write interval, an address-only write and a foreign device type, none of which may start programming or move the pointer;
- extra clocks after a master NACK, which must find the line released.

// File: rtl/i2cmem_pkg.sv
// Shared types for the two-wire serial memory slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cmem_pkg;
    // Bus-level phase of the slave protocol engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_TXACK
    } phase_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        BY_DEV,
        BY_AHI,
        BY_ALO,
        BY_DATA
    } byte_t;
endpackage

// File: rtl/i2cmem_line_sync.sv
// Synchronises raw SCL/SDA into the clock domain and reports bus events.
// Assumes: the bus runs far slower than clk, so each level is held for
// several clocks; both lines idle high.
module i2cmem_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q, sda_q, scl_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Metastability pipeline plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    // Event decode: SDA moving while SCL stays high marks start/stop
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cmem_store.sv
// Byte store plus the self-timed programming interval counter.
// Assumes: the controller never writes while busy; read data is combinational.
module i2cmem_store #(
    parameter int ADDR_W       = 13,
    parameter int WRITE_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              cycle_start,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(WRITE_CYCLES + 1);

    logic [7:0]    cells [DEPTH];
    logic [CW-1:0] remain;

    // Byte write port; contents are not reset
    always_ff @(posedge clk) begin
        if (wr_en) cells[addr] <= wr_data;
    end

    assign rd_data = cells[addr];

    // Countdown for the programming interval
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (cycle_start)  remain <= CW'(WRITE_CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    a_r5_busy_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> busy);
    a_r5_no_store_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);
endmodule

// File: rtl/i2cmem_ctrl.sv
// Protocol engine: address match, word address capture, write path,
// read streaming and acknowledge handling.
// Assumes: events from i2cmem_line_sync are single-cycle pulses; ADDR_W is 9..16.
module i2cmem_ctrl
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W     = 13,
    parameter int         PAGE_BYTES = 64,
    parameter logic [3:0] DEV_TYPE   = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wr_data,
    output logic              cycle_start
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    phase_t     phase;
    byte_t      kind;
    logic [3:0] nbits;
    logic [7:0] shreg;
    logic       rw, mack, wr_seen;

    // Order of received bytes within a write transaction
    function automatic byte_t next_kind(input byte_t k);
        case (k)
            BY_DEV:  return BY_AHI;
            BY_AHI:  return BY_ALO;
            default: return BY_DATA;
        endcase
    endfunction

    // A data byte is stored on the falling edge that closes its eighth bit
    assign wr_en = (phase == PH_RX) && (kind == BY_DATA) && (nbits == 4'd8) &&
                   scl_fall && !start_det && !stop_det;
    assign wr_data     = shreg;
    assign cycle_start = stop_det && wr_seen;
    assign sda_oe      = (phase == PH_ACK) || ((phase == PH_TX) && !shreg[7]);

    // Main protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            kind    <= BY_DEV;
            nbits   <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            wr_seen <= 1'b0;
            addr    <= '0;
        end else if (start_det) begin
            phase   <= PH_RX;
            kind    <= BY_DEV;
            nbits   <= '0;
            wr_seen <= 1'b0;
        end else if (stop_det) begin
            phase   <= PH_IDLE;
            wr_seen <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (scl_rise && nbits != 4'd8) begin
                        shreg <= {shreg[6:0], sda_s};
                        nbits <= nbits + 1'b1;
                    end else if (scl_fall && nbits == 4'd8) begin
                        case (kind)
                            BY_DEV: begin
                                if (shreg[7:4] == DEV_TYPE && !busy) begin
                                    rw    <= shreg[0];
                                    phase <= PH_ACK;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            BY_AHI: begin
                                addr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
                                phase <= PH_ACK;
                            end
                            BY_ALO: begin
                                addr[7:0] <= shreg;
                                phase <= PH_ACK;
                            end
                            default: begin
                                addr    <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                                wr_seen <= 1'b1;
                                phase   <= PH_ACK;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        nbits <= '0;
                        if (kind == BY_DEV && rw) begin
                            phase <= PH_TX;
                            shreg <= rd_data;
                            addr  <= addr + 1'b1;
                        end else begin
                            phase <= PH_RX;
                            kind  <= next_kind(kind);
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (nbits == 4'd7) begin
                            phase <= PH_TXACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                            nbits <= nbits + 1'b1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        mack <= !sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            phase <= PH_TX;
                            shreg <= rd_data;
                            addr  <= addr + 1'b1;
                            nbits <= '0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    a_r10_release_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));
    a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACK && kind == BY_DEV) |-> !busy);
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/i2c_mem_slave.sv
// Top level of the two-wire serial memory slave.
// Assumes: sda_oe drives an open-drain pad; sda_i sees the wired line level.
module i2c_mem_slave #(
    parameter int         ADDR_W       = 13,
    parameter int         PAGE_BYTES   = 64,
    parameter int         WRITE_CYCLES = 1000000,
    parameter logic [3:0] DEV_TYPE     = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic busy
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, cycle_start;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wr_data, rd_data;

    i2cmem_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cmem_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DEV_TYPE(DEV_TYPE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .cycle_start(cycle_start)
    );

    i2cmem_store #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .cycle_start(cycle_start), .rd_data(rd_data),
        .busy(busy)
    );
endmodule

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
// Bench: a behavioural bus master plus a memory/pointer model of the slave.
module i2c_mem_slave_test;
    localparam int H  = 10;
    localparam int WC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe, busy;
    wire  line = sda_drv & ~sda_oe;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    logic [7:0] exp_mem [0:8191];
    int exp_ptr = 0;

    always #2.5 clk = ~clk;

    i2c_mem_slave #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(line),
        .sda_oe(sda_oe), .busy(busy)
    );

    // Watchdog and cycle count
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start;
        sda_drv = 1'b1; tick(H); scl_drv = 1'b1; tick(H);
        sda_drv = 1'b0; tick(H); scl_drv = 1'b0; tick(2);
    endtask

    task automatic do_stop;
        sda_drv = 1'b0; tick(H); scl_drv = 1'b1; tick(H);
        sda_drv = 1'b1; tick(H);
    endtask

    task automatic clock_bit(input logic b, output logic r);
        sda_drv = b; tick(H); scl_drv = 1'b1; tick(H/2);
        r = line; tick(H/2); scl_drv = 1'b0; tick(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        acked = !r;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            b[i] = r;
        end
        clock_bit(!give_ack, r);
    endtask

    // Write n bytes (n may be 0) and update the model
    task automatic wr_txn(input logic [7:0] dev, input logic [15:0] a, input int n,
                          input logic [7:0] first);
        logic ack; int ad;
        do_start;
        put_byte(dev, ack);    chk(ack, "R2", ack, 1);
        put_byte(a[15:8], ack); chk(ack, "R3", ack, 1);
        put_byte(a[7:0], ack);  chk(ack, "R3", ack, 1);
        ad = int'(a) & 8191;
        for (int i = 0; i < n; i++) begin
            put_byte(first + 8'(i), ack); chk(ack, "R3", ack, 1);
            exp_mem[ad] = first + 8'(i);
            ad = (ad & ~63) | ((ad + 1) & 63);
        end
        do_stop;
        exp_ptr = ad;
        chk(busy == (n > 0), "R5", busy, n > 0);
    endtask

    // Poll during the write interval, then check its length
    task automatic finish_write;
        logic ack; int t0;
        t0 = cyc;
        do_start; put_byte(8'hA0, ack); chk(!ack, "R5", ack, 0); do_stop;
        while (cyc < t0 + WC - 25) tick(1);
        chk(busy == 1'b1, "R5", busy, 1);
        while (cyc < t0 + WC + 10) tick(1);
        chk(busy == 1'b0, "R5", busy, 0);
    endtask

    task automatic rd_random(input logic [15:0] a, input int n, input bit probe);
        logic ack, r; logic [7:0] b; int ad;
        do_start;
        put_byte(8'hA0, ack);   chk(ack, "R6", ack, 1);
        put_byte(a[15:8], ack); chk(ack, "R6", ack, 1);
        put_byte(a[7:0], ack);  chk(ack, "R6", ack, 1);
        do_start;
        put_byte(8'hA1, ack);   chk(ack, "R6", ack, 1);
        ad = int'(a) & 8191;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            chk(b == exp_mem[ad], (i == 0) ? "R6" : "R7", b, exp_mem[ad]);
            ad = (ad + 1) & 8191;
        end
        if (probe) begin
            for (int i = 0; i < 9; i++) begin
                clock_bit(1'b1, r); chk(r == 1'b1, "R9", r, 1);
            end
        end
        do_stop;
        exp_ptr = ad;
    endtask

    task automatic rd_current(input int n);
        logic ack; logic [7:0] b;
        do_start;
        put_byte(8'hA1, ack); chk(ack, "R8", ack, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            chk(b == exp_mem[exp_ptr], "R8", b, exp_mem[exp_ptr]);
            exp_ptr = (exp_ptr + 1) & 8191;
        end
        do_stop;
    endtask

    initial begin
        logic ack;
        tick(5); rst_n = 1'b1; tick(2);
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        chk(busy == 1'b0, "R1", busy, 0);

        wr_txn(8'hA0, 16'hE123, 5, 8'h10);   // R3: upper bits of first address byte ignored
        finish_write;
        rd_random(16'h0123, 3, 1'b1);        // R6, R7, R9
        rd_current(2);                       // R8 across stop

        wr_txn(8'hAE, 16'h0200, 1, 8'h77);   // R2: select bits don't-care
        finish_write;
        wr_txn(8'hA0, 16'h01FE, 4, 8'h30);   // R4: page wrap
        finish_write;
        rd_random(16'h01FE, 2, 1'b0);
        rd_current(1);                       // R4: next page untouched (0x200)
        rd_random(16'h01C0, 2, 1'b0);        // R4: wrapped bytes at page start

        wr_txn(8'hA0, 16'h1FFF, 1, 8'h5A); finish_write;
        wr_txn(8'hA0, 16'h0000, 1, 8'hA5); finish_write;
        rd_random(16'h1FFF, 2, 1'b0);        // R7: 8191 -> 0

        wr_txn(8'hA0, 16'h0124, 0, 8'h00);   // R5/R8: address-only write
        rd_current(1);

        do_start;                            // R2: foreign device type
        put_byte(8'h90, ack); chk(!ack, "R2", ack, 0);
        put_byte(8'h01, ack); chk(!ack, "R2", ack, 0);
        put_byte(8'h55, ack); chk(!ack, "R2", ack, 0);
        do_stop;
        chk(busy == 1'b0, "R2", busy, 0);
        rd_current(1);                       // R2/R8: pointer and data unchanged

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule